// File: doc/BRIEF.md
# Serial Access Memory Port

This block models the serial side of a dual-port video memory. A buffer as wide as one row of the main array sits between the array and a word-wide serial stream. Transfer commands move whole rows in either direction. A read transfer fills the buffer from a chosen array row. A write transfer stores the buffer into a chosen array row, with a per-bit mask applied. Both transfer types also load the serial column counter with a start column.

Between transfers the buffer is streamed one word per serial clock tick, starting at the counter's column. The port is always in read mode or in write mode. In read mode it drives the buffer word onto the output bus. In write mode it captures the input bus into the buffer. Only a transfer of the matching type changes the mode. The serial enable input (active low) gates the data movement. It does not gate the counter, which advances on every tick and wraps from the last column to column 0.

Top module: `sam_port`

## Requirements
- R1: After reset the port is in read mode (`mode_wr_o` = 0), the column counter is 0, and every array word and buffer word is 0.
- R2: A cycle with `rd_xfer_i` = 1 copies array row `xfer_row_i` into the buffer, loads the counter with `xfer_col_i`, and sets read mode. From the next cycle on, the buffer data and mode are visible. If the port is already in read mode it stays there.
- R3: A cycle with `wr_xfer_i` = 1 (and `rd_xfer_i` = 0) stores the buffer into array row `xfer_row_i`, loads the counter with `xfer_col_i`, and sets write mode. For every bit position i, each array word takes buffer bit i where `xfer_mask_i[i]` = 1 and keeps its old bit where `xfer_mask_i[i]` = 0.
- R4: A write transfer with `xfer_mask_i` = 0 leaves the array unchanged and still switches the port to write mode.
- R5: In read mode with `se_ni` = 0, `sd_oe_o` = 1 and `sd_o` shows the buffer word at the current counter column.
- R6: In write mode with `se_ni` = 0, a cycle with `sc_tick_i` = 1 writes `sd_i` into the buffer word at the current counter column.
- R7: With `se_ni` = 1, `sd_oe_o` = 0 and serial ticks write nothing into the buffer.
- R8: Every `sc_tick_i` cycle without a transfer advances the counter by one, whatever the values of `se_ni` and the mode. The counter wraps from column 2^COL_W-1 to 0.
- R9: A transfer takes priority over a tick in the same cycle: the counter takes the start column and no serial write occurs. If both transfer inputs are high in the same cycle, the read transfer is performed.
- R10: In write mode `sd_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_xfer_i | input | 1 | Read transfer command (array row to buffer) |
| wr_xfer_i | input | 1 | Write transfer command (buffer to array row) |
| xfer_row_i | input | ROW_W | Array row for the transfer |
| xfer_col_i | input | COL_W | Start column loaded into the counter |
| xfer_mask_i | input | WORD_W | Per-bit store mask for write transfers, 1 = store |
| sc_tick_i | input | 1 | Serial clock tick |
| se_ni | input | 1 | Serial enable, active low |
| sd_i | input | WORD_W | Serial write data |
| sd_o | output | WORD_W | Serial read data |
| sd_oe_o | output | 1 | Output enable for sd_o |
| mode_wr_o | output | 1 | Current mode: 1 = write, 0 = read |

## Verification
The hardest case to reach from the ports is a counter that moves while nothing else does. The counter is not a port, so its advance while serial enable is high has to be inferred. The bench does this by ticking with the port disabled, then re-enabling it and checking that the output word comes from the column that many steps further on, past the wrap. The array contents can only be seen through a read transfer. So the unchanged-row case for an all-blocked write transfer, and the partial-mask merge, are each checked by a full-row readback. The data is first written into the buffer serially.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic {
    SAM_RD = 1'b0,
    SAM_WR = 1'b1
  } sam_mode_e;
endpackage

// File: rtl/sam_array.sv
module sam_array #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4,
  parameter int WORD_W = 16,
  localparam int ROWS  = 1 << ROW_W,
  localparam int COLS  = 1 << COL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          store_i,
  input  logic [ROW_W-1:0]              row_i,
  input  logic [WORD_W-1:0]             mask_i,
  input  logic [COLS-1:0][WORD_W-1:0]   wrow_i,
  output logic [COLS-1:0][WORD_W-1:0]   rrow_o
);
  logic [COLS-1:0][WORD_W-1:0] rows_w [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0][WORD_W-1:0] row_q;
    logic                        hit;
    assign hit = store_i && (row_i == ROW_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (hit) begin
        for (int c = 0; c < COLS; c++) begin
          row_q[c] <= (row_q[c] & ~mask_i) | (wrow_i[c] & mask_i);
        end
      end
    end
    assign rows_w[r] = row_q;
  end

  assign rrow_o = rows_w[row_i];
endmodule

// File: rtl/sam_buffer.sv
module sam_buffer #(
  parameter int COL_W  = 4,
  parameter int WORD_W = 16,
  localparam int COLS  = 1 << COL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [COLS-1:0][WORD_W-1:0]   lrow_i,
  input  logic                          wr_i,
  input  logic [COL_W-1:0]              col_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [COLS-1:0][WORD_W-1:0]   row_o,
  output logic [WORD_W-1:0]             word_o
);
  logic [COLS-1:0][WORD_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (load_i) row_q <= lrow_i;
    else if (wr_i)   row_q[col_i] <= wdata_i;
  end

  assign row_o  = row_q;
  assign word_o = row_q[col_i];
endmodule

// File: rtl/sam_counter.sv
module sam_counter #(
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [COL_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (tick_i) cnt_o <= cnt_o + COL_W'(1); // wraps by width
  end
endmodule

// File: rtl/sam_mode.sv
module sam_mode
  import sam_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_xfer_i,
  input  logic      wr_xfer_i,
  output sam_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_o <= SAM_RD;
    else if (rd_xfer_i) mode_o <= SAM_RD;
    else if (wr_xfer_i) mode_o <= SAM_WR;
  end
endmodule

// File: rtl/sam_port.sv
module sam_port
  import sam_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4,
  parameter int WORD_W = 16,
  localparam int COLS  = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_xfer_i,
  input  logic              wr_xfer_i,
  input  logic [ROW_W-1:0]  xfer_row_i,
  input  logic [COL_W-1:0]  xfer_col_i,
  input  logic [WORD_W-1:0] xfer_mask_i,
  input  logic              sc_tick_i,
  input  logic              se_ni,
  input  logic [WORD_W-1:0] sd_i,
  output logic [WORD_W-1:0] sd_o,
  output logic              sd_oe_o,
  output logic              mode_wr_o
);
  sam_mode_e                   mode_q;
  logic [COL_W-1:0]            cnt_q;
  logic [COLS-1:0][WORD_W-1:0] arr_row, buf_row;
  logic [WORD_W-1:0]           buf_word;
  logic                        xfer_any, store, ser_wr;

  assign xfer_any = rd_xfer_i | wr_xfer_i;
  assign store    = wr_xfer_i & ~rd_xfer_i;
  // transfer owns the cycle; serial data only moves when enabled
  assign ser_wr   = sc_tick_i & ~se_ni & (mode_q == SAM_WR) & ~xfer_any;

  sam_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_xfer_i (rd_xfer_i),
    .wr_xfer_i (wr_xfer_i),
    .mode_o    (mode_q)
  );

  sam_counter #(.COL_W(COL_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (xfer_any),
    .load_val_i (xfer_col_i),
    .tick_i     (sc_tick_i),
    .cnt_o      (cnt_q)
  );

  sam_array #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .store_i (store),
    .row_i   (xfer_row_i),
    .mask_i  (xfer_mask_i),
    .wrow_i  (buf_row),
    .rrow_o  (arr_row)
  );

  sam_buffer #(.COL_W(COL_W), .WORD_W(WORD_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_xfer_i),
    .lrow_i  (arr_row),
    .wr_i    (ser_wr),
    .col_i   (cnt_q),
    .wdata_i (sd_i),
    .row_o   (buf_row),
    .word_o  (buf_word)
  );

  assign sd_oe_o   = ~se_ni & (mode_q == SAM_RD);
  assign sd_o      = sd_oe_o ? buf_word : '0;
  assign mode_wr_o = (mode_q == SAM_WR);
endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
  parameter int COL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_xfer_i,
  input logic             wr_xfer_i,
  input logic [COL_W-1:0] xfer_col_i,
  input logic             sc_tick_i,
  input logic             se_ni,
  input logic             sd_oe_o,
  input logic             mode_wr_o,
  input logic [COL_W-1:0] cnt_q
);
  assert_rd_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_xfer_i |=> !mode_wr_o);

  assert_wr_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_xfer_i && !rd_xfer_i) |=> mode_wr_o);

  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_xfer_i && !wr_xfer_i) |=> $stable(mode_wr_o));

  assert_off_when_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_ni |-> !sd_oe_o);

  assert_off_in_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_o |-> !sd_oe_o);

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_tick_i && !rd_xfer_i && !wr_xfer_i) |=> cnt_q == COL_W'($past(cnt_q) + 1'b1));

  assert_cnt_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_xfer_i || wr_xfer_i) |=> cnt_q == $past(xfer_col_i));

  assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_tick_i && !rd_xfer_i && !wr_xfer_i) |=> $stable(cnt_q));
endmodule

bind sam_port sam_port_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_sam_port.sv
module tb_sam_port;
  localparam int ROW_W = 3, COL_W = 4, WORD_W = 16;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd_xfer = 0, wr_xfer = 0, sc_tick = 0, se_ni = 0;
  logic [ROW_W-1:0] xrow = '0;
  logic [COL_W-1:0] xcol = '0;
  logic [WORD_W-1:0] xmask = '0, sd_i = '0, sd_o;
  logic sd_oe_o, mode_wr_o;

  logic [WORD_W-1:0] exp_mem [ROWS][COLS];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sam_port #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_xfer_i(rd_xfer), .wr_xfer_i(wr_xfer),
    .xfer_row_i(xrow), .xfer_col_i(xcol), .xfer_mask_i(xmask),
    .sc_tick_i(sc_tick), .se_ni(se_ni), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .mode_wr_o(mode_wr_o)
  );

  function automatic logic [WORD_W-1:0] pat(int r, int c, int salt);
    return WORD_W'((r * 16'h1357) ^ (c * 16'h0241) ^ (salt * 16'h3C1D) ^ 16'hA5C3);
  endfunction

  task automatic check(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic xfer(bit rd, bit wr, int row, int col, logic [WORD_W-1:0] m, bit tk);
    rd_xfer = rd; wr_xfer = wr; xrow = ROW_W'(row); xcol = COL_W'(col);
    xmask = m; sc_tick = tk;
    @(negedge clk);
    rd_xfer = 0; wr_xfer = 0; sc_tick = 0; xmask = '0;
  endtask

  task automatic ser_tick(logic [WORD_W-1:0] d);
    sd_i = d; sc_tick = 1;
    @(negedge clk);
    sc_tick = 0;
  endtask

  task automatic read_row_check(int r, int s, string tag);
    xfer(1, 0, r, s, '0, 0);
    check({tag, " R2 mode"}, WORD_W'(mode_wr_o), '0);
    for (int k = 0; k < COLS; k++) begin
      check({tag, " R5 oe"}, WORD_W'(sd_oe_o), 1);
      check({tag, " R8 word"}, sd_o, exp_mem[r][(s + k) % COLS]);
      ser_tick('0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) exp_mem[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 mode", WORD_W'(mode_wr_o), '0);
    check("R1 oe", WORD_W'(sd_oe_o), 1);
    check("R1 word", sd_o, '0);
    read_row_check(5, 0, "R1 array");

    // R3/R6 fill every row serially then store it
    for (int r = 0; r < ROWS; r++) begin
      xfer(0, 1, r, 0, '0, 0);
      check("R4 mode", WORD_W'(mode_wr_o), 1);
      check("R10 oe", WORD_W'(sd_oe_o), 0);
      for (int c = 0; c < COLS; c++) ser_tick(pat(r, c, 0));
      xfer(0, 1, r, 0, '1, 0);
      for (int c = 0; c < COLS; c++) exp_mem[r][c] = pat(r, c, 0);
    end

    // R2/R8 read back every row from a varying start column
    for (int r = 0; r < ROWS; r++) read_row_check(r, (r * 5 + 3) % COLS, "R6 fill");
    read_row_check(2, 2, "R2 reread");

    // R4 all-blocked write transfer keeps row 0; buffer holds row 2
    xfer(0, 1, 0, 0, '0, 0);
    check("R4 switch", WORD_W'(mode_wr_o), 1);
    read_row_check(0, 0, "R4 row kept");

    // R3 partial mask merge
    xfer(0, 1, 1, 0, '0, 0);
    for (int c = 0; c < COLS; c++) ser_tick(pat(1, c, 7));
    xfer(0, 1, 1, 0, 16'h0F0F, 0);
    for (int c = 0; c < COLS; c++)
      exp_mem[1][c] = (exp_mem[1][c] & ~16'h0F0F) | (pat(1, c, 7) & 16'h0F0F);
    read_row_check(1, 0, "R3 merge");

    // R7/R8 counter advances while disabled, wrapping past the end
    xfer(1, 0, 2, 14, '0, 0);
    se_ni = 1;
    #1;
    check("R7 oe off", WORD_W'(sd_oe_o), 0);
    #0;
    for (int k = 0; k < 3; k++) ser_tick('0);
    se_ni = 0;
    #1;
    check("R8 disabled ticks", sd_o, exp_mem[2][1]);

    // R7 disabled serial writes leave buffer (row 2 data) intact
    @(negedge clk);
    xfer(1, 0, 2, 0, '0, 0);
    xfer(0, 1, 3, 0, '0, 0);
    se_ni = 1;
    for (int k = 0; k < 5; k++) ser_tick(16'hDEAD);
    se_ni = 0;
    xfer(0, 1, 3, 0, '1, 0);
    for (int c = 0; c < COLS; c++) exp_mem[3][c] = exp_mem[2][c];
    read_row_check(3, 0, "R7 no write");

    // R9 transfer wins over a same-cycle tick
    xfer(1, 0, 4, 9, '0, 1);
    check("R9 tick ignored", sd_o, exp_mem[4][9]);
    // R9 both transfers: read wins, array untouched
    xfer(0, 1, 6, 0, '0, 0);
    xfer(1, 1, 6, 5, '1, 0);
    check("R9 both mode", WORD_W'(mode_wr_o), 0);
    check("R9 both word", sd_o, exp_mem[6][5]);
    read_row_check(6, 0, "R9 both row");
    // R9 no serial write during a write transfer with tick
    xfer(0, 1, 7, 0, '0, 0);
    for (int c = 0; c < COLS; c++) ser_tick(pat(7, c, 3));
    sd_i = 16'hBEEF;
    xfer(0, 1, 7, 2, '1, 1);
    for (int c = 0; c < COLS; c++) exp_mem[7][c] = pat(7, c, 3);
    read_row_check(7, 0, "R9 wr tick");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule